// File: doc/BRIEF.md
# SCSI Transfer Byte Counter

This block tracks how many bytes a SCSI data transfer has left and where in host memory the next byte goes. Software loads a 24-bit remaining-byte count and a 32-bit host address through an 8-bit register port, one byte lane per register. Each confirmed byte transfer, signalled by a one-cycle pulse from the data path, lowers the count by one and raises the address by one in the same clock. The address therefore always points at the next byte to move.

Two sticky flags report progress. A completion flag is raised when a confirmed transfer brings the count to zero. A rollover flag is raised when a transfer is confirmed while the count is already zero. Software clears either flag by writing a one to its bit. A single interrupt line combines both flags, and each flag has its own enable. A control bit also lets software clear the whole count in one write.

Top module: `xfer_byte_counter`

## Requirements
- R1: After reset the count, the address, both flags and both interrupt enables are zero, and every register reads 0x00.
- R2: Count bytes sit at offsets 0, 1 and 2, and address bytes at offsets 3 to 6, low byte first in each case. A write replaces only the addressed byte, and a read returns the current value of that byte.
- R3: A cycle with `xfer_i` high lowers the count by one and raises the address by one. Both new values are visible from the next cycle, and the address carries across all 32 bits.
- R4: With `xfer_i` low and no write, the count and the address hold their values.
- R5: The completion flag (status register at offset 7, bit 0) is set when a pulse takes the count from 1 to 0. Loading or clearing the count to zero does not set it. Once cleared, it stays clear while the count remains zero.
- R6: The rollover flag (offset 7, bit 1) is set when a pulse arrives while the count is zero. The count then becomes 0xFFFFFF.
- R7: Writing offset 7 clears each flag whose data bit is 1 and leaves a flag alone where the data bit is 0. If a set event falls in the same cycle as the clear, the flag ends up set.
- R8: Writing offset 8 with bit 2 set clears the count to zero and leaves the address unchanged. Bit 2 always reads back as 0.
- R9: When a write to a count byte, an address byte or the count-clear bit falls in the same cycle as a pulse, the write takes effect and the pulse is dropped for both count and address. A write to offset 7, or to offset 8 without bit 2, does not block a pulse.
- R10: `irq_o` is high exactly when (completion flag AND enable bit 0 of offset 8) OR (rollover flag AND enable bit 1 of offset 8).
- R11: Offsets 9 to 15 read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational readback of the register at `reg_addr_i` |
| xfer_i | input | 1 | One-cycle pulse per confirmed byte transfer |
| irq_o | output | 1 | Combined enabled flag interrupt |

## Verification
The assertions assume that `xfer_i` is a single-cycle pulse that reflects a completed byte. They also assume that the register port presents at most one write per cycle and holds its address stable across the edge. The bench drives every input on the falling clock edge and releases a pulse after one cycle. Where it deliberately overlaps a pulse with a register write, it does so only in the collision scenarios that R7 and R9 describe.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_WRAP = 1;
  localparam int unsigned CT_CLR  = 2;

  typedef struct packed {
    logic wrap;
    logic done;
  } xbc_flags_t;
endpackage

// File: rtl/xbc_lane_counter.sv
module xbc_lane_counter #(
  parameter int unsigned LANES = 3,
  parameter bit          DOWN  = 1'b1,
  localparam int unsigned W    = LANES * xbc_pkg::BYTE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic [LANES-1:0]            lane_we_i,
  input  logic [xbc_pkg::BYTE_W-1:0]  wdata_i,
  input  logic                        step_i,
  output logic [W-1:0]                value_o
);
  localparam int unsigned BW = xbc_pkg::BYTE_W;

  logic [W-1:0] value_q;
  logic [W-1:0] merged;
  logic [W-1:0] stepped;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign merged[k*BW +: BW] = lane_we_i[k] ? wdata_i : value_q[k*BW +: BW];
  end

  if (DOWN) begin : g_down
    assign stepped = value_q - W'(1);
  end else begin : g_up
    assign stepped = value_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          value_q <= '0;
    else if (clr_i)       value_q <= '0;
    else if (|lane_we_i)  value_q <= merged;
    else if (step_i)      value_q <= stepped;
  end

  assign value_o = value_q;
endmodule

// File: rtl/xbc_flags.sv
module xbc_flags
  import xbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xbc_flags_t set_i,
  input  logic       clr_we_i,
  input  xbc_flags_t clr_mask_i,
  input  xbc_flags_t en_i,
  output xbc_flags_t flags_o,
  output logic       irq_o
);
  xbc_flags_t flags_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_mask_i : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_eff) | set_i;
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/xfer_byte_counter.sv
module xfer_byte_counter
  import xbc_pkg::*;
#(
  parameter int unsigned CNT_BYTES = 3,
  parameter int unsigned ADR_BYTES = 4,
  parameter int unsigned RA_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              xfer_i,
  output logic              irq_o
);
  localparam int unsigned CNT_W    = CNT_BYTES * BYTE_W;
  localparam int unsigned ADR_W    = ADR_BYTES * BYTE_W;
  localparam int unsigned ADR_BASE = CNT_BYTES;
  localparam int unsigned STS_OFF  = CNT_BYTES + ADR_BYTES;
  localparam int unsigned CTL_OFF  = STS_OFF + 1;

  logic [CNT_BYTES-1:0] cnt_we;
  logic [ADR_BYTES-1:0] adr_we;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADR_W-1:0]     adr_q;
  logic                 sts_we, ctl_we, clr_cmd, blocked, step;
  xbc_flags_t           set_ev, flags, en_q;

  for (genvar k = 0; k < CNT_BYTES; k++) begin : g_cnt_we
    assign cnt_we[k] = reg_we_i && (reg_addr_i == RA_W'(k));
  end
  for (genvar k = 0; k < ADR_BYTES; k++) begin : g_adr_we
    assign adr_we[k] = reg_we_i && (reg_addr_i == RA_W'(ADR_BASE + k));
  end

  assign sts_we  = reg_we_i && (reg_addr_i == RA_W'(STS_OFF));
  assign ctl_we  = reg_we_i && (reg_addr_i == RA_W'(CTL_OFF));
  assign clr_cmd = ctl_we && reg_wdata_i[CT_CLR];
  // any write touching the counters drops a coincident transfer
  assign blocked = (|cnt_we) || (|adr_we) || clr_cmd;
  assign step    = xfer_i && !blocked;

  xbc_lane_counter #(.LANES(CNT_BYTES), .DOWN(1'b1)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_cmd),
    .lane_we_i(cnt_we),
    .wdata_i  (reg_wdata_i),
    .step_i   (step),
    .value_o  (cnt_q)
  );

  xbc_lane_counter #(.LANES(ADR_BYTES), .DOWN(1'b0)) u_adr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (1'b0),
    .lane_we_i(adr_we),
    .wdata_i  (reg_wdata_i),
    .step_i   (step),
    .value_o  (adr_q)
  );

  assign set_ev.done = step && (cnt_q == CNT_W'(1));
  assign set_ev.wrap = step && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (ctl_we) en_q <= xbc_flags_t'(reg_wdata_i[1:0]);
  end

  xbc_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_ev),
    .clr_we_i  (sts_we),
    .clr_mask_i(xbc_flags_t'(reg_wdata_i[1:0])),
    .en_i      (en_q),
    .flags_o   (flags),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int k = 0; k < CNT_BYTES; k++)
      if (reg_addr_i == RA_W'(k)) reg_rdata_o = cnt_q[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < ADR_BYTES; k++)
      if (reg_addr_i == RA_W'(ADR_BASE + k)) reg_rdata_o = adr_q[k*BYTE_W +: BYTE_W];
    if (reg_addr_i == RA_W'(STS_OFF)) reg_rdata_o = {{(BYTE_W-2){1'b0}}, flags};
    if (reg_addr_i == RA_W'(CTL_OFF)) reg_rdata_o = {{(BYTE_W-2){1'b0}}, en_q};
  end
endmodule

// File: rtl/xbc_checker.sv
module xbc_checker #(
  parameter int unsigned CNT_W   = 24,
  parameter int unsigned ADR_W   = 32,
  parameter int unsigned RA_W    = 4,
  parameter int unsigned STS_OFF = 7,
  parameter int unsigned CTL_OFF = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic             reg_we_i,
  input logic [7:0]       reg_wdata_i,
  input logic             xfer_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [ADR_W-1:0] adr_i,
  input logic [1:0]       flags_i,
  input logic             irq_i
);
  logic blk;
  assign blk = reg_we_i && ((reg_addr_i < RA_W'(STS_OFF)) ||
               ((reg_addr_i == RA_W'(CTL_OFF)) && reg_wdata_i[2]));

  AST_STEP_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !blk |=> (cnt_i == $past(cnt_i) - CNT_W'(1)) && (adr_i == $past(adr_i) + ADR_W'(1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i && !reg_we_i |=> $stable(cnt_i) && $stable(adr_i)); // R4
  AST_DONE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !blk && cnt_i == CNT_W'(1) |=> flags_i[0]); // R5
  AST_WRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !blk && cnt_i == '0 |=> flags_i[1] && (cnt_i == '1)); // R6
  AST_DONE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == RA_W'(STS_OFF) && reg_wdata_i[0] && !(xfer_i && !blk && cnt_i == CNT_W'(1))
    |=> !flags_i[0]); // R7
  AST_CLR_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == RA_W'(CTL_OFF) && reg_wdata_i[2] |=> cnt_i == '0 && $stable(adr_i)); // R8
  AST_BLOCKED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && reg_we_i && reg_addr_i < RA_W'(STS_OFF - 4) |=> $stable(adr_i)); // R9
  AST_NO_IRQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i == 2'b00 |-> !irq_i); // R10
endmodule

bind xfer_byte_counter xbc_checker #(
  .CNT_W(CNT_W), .ADR_W(ADR_W), .RA_W(RA_W), .STS_OFF(STS_OFF), .CTL_OFF(CTL_OFF)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_wdata_i(reg_wdata_i),
  .xfer_i     (xfer_i),
  .cnt_i      (cnt_q),
  .adr_i      (adr_q),
  .flags_i    (flags),
  .irq_i      (irq_o)
);

// File: tb/xfer_byte_counter_tb.sv
module xfer_byte_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       xfer = 1'b0;
  logic       irq;
  int         errors = 0;
  int         checks = 0;
  bit         done_run = 1'b0;

  always #5 clk = ~clk;

  xfer_byte_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .xfer_i(xfer), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_cnt(output logic [31:0] v);
    logic [7:0] b0, b1, b2;
    rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
    v = {8'h00, b2, b1, b0};
  endtask

  task automatic rd_adr(output logic [31:0] v);
    logic [7:0] b0, b1, b2, b3;
    rd(4'd3, b0); rd(4'd4, b1); rd(4'd5, b2); rd(4'd6, b3);
    v = {b3, b2, b1, b0};
  endtask

  task automatic load(logic [23:0] c, logic [31:0] a);
    for (int k = 0; k < 3; k++) wr(4'(k), c[k*8 +: 8]);
    for (int k = 0; k < 4; k++) wr(4'(3 + k), a[k*8 +: 8]);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); xfer = 1'b1;
      @(negedge clk); xfer = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d); chk("R1 reset readback", {24'h0, d}, 32'h0);
    end
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_lanes();
    logic [31:0] v;
    load(24'hA1B2C3, 32'h11223344);
    rd_cnt(v); chk("R2 count lanes", v, 32'h00A1B2C3);
    rd_adr(v); chk("R2 address lanes", v, 32'h11223344);
    wr(4'd1, 8'h5A);
    rd_cnt(v); chk("R2 single lane write", v, 32'h00A15AC3);
    repeat (3) @(negedge clk);
    rd_cnt(v); chk("R4 count holds", v, 32'h00A15AC3);
    rd_adr(v); chk("R4 address holds", v, 32'h11223344);
  endtask

  task automatic t_done_wrap();
    logic [31:0] v; logic [7:0] s;
    wr(4'd7, 8'h03);
    load(24'h000003, 32'hFFFFFFFE);
    rd(4'd7, s); chk("R5 no done on load", {24'h0, s}, 32'h0);
    pulses(2);
    rd_cnt(v); chk("R3 count after two", v, 32'h1);
    rd_adr(v); chk("R3 address carry", v, 32'h0);
    rd(4'd7, s); chk("R5 done not early", {24'h0, s}, 32'h0);
    pulses(1);
    rd(4'd7, s); chk("R5 done set at zero", {24'h0, s}, 32'h1);
    wr(4'd7, 8'h01);
    repeat (2) @(negedge clk);
    rd(4'd7, s); chk("R5 done stays clear", {24'h0, s}, 32'h0);
    pulses(1);
    rd_cnt(v); chk("R6 count rolls over", v, 32'h00FFFFFF);
    rd_adr(v); chk("R6 address keeps stepping", v, 32'h2);
    rd(4'd7, s); chk("R6 wrap flag", {24'h0, s}, 32'h2);
    wr(4'd7, 8'h01);
    rd(4'd7, s); chk("R7 zero bit leaves wrap", {24'h0, s}, 32'h2);
    wr(4'd7, 8'h02);
    rd(4'd7, s); chk("R7 wrap cleared", {24'h0, s}, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [7:0] s;
    load(24'h000001, 32'h0);
    @(negedge clk); addr = 4'd7; wdata = 8'h01; we = 1'b1; xfer = 1'b1;
    @(negedge clk); we = 1'b0; xfer = 1'b0;
    rd(4'd7, s); chk("R7 set wins over clear", {24'h0, s}, 32'h1);
    wr(4'd7, 8'h03);
  endtask

  task automatic t_clear_cmd();
    logic [31:0] v; logic [7:0] s;
    load(24'h123456, 32'h00000100);
    wr(4'd8, 8'h04);
    rd_cnt(v); chk("R8 count cleared", v, 32'h0);
    rd_adr(v); chk("R8 address untouched", v, 32'h100);
    rd(4'd8, s); chk("R8 clear bit reads zero", {24'h0, s}, 32'h0);
    rd(4'd7, s); chk("R8 no done from clear", {24'h0, s}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    load(24'h000010, 32'h00000020);
    @(negedge clk); addr = 4'd1; wdata = 8'h55; we = 1'b1; xfer = 1'b1;
    @(negedge clk); we = 1'b0; xfer = 1'b0;
    rd_cnt(v); chk("R9 write wins on count", v, 32'h00005510);
    rd_adr(v); chk("R9 address not stepped", v, 32'h20);
    @(negedge clk); addr = 4'd4; wdata = 8'h01; we = 1'b1; xfer = 1'b1;
    @(negedge clk); we = 1'b0; xfer = 1'b0;
    rd_cnt(v); chk("R9 count not stepped", v, 32'h00005510);
    rd_adr(v); chk("R9 address byte written", v, 32'h120);
    @(negedge clk); addr = 4'd8; wdata = 8'h00; we = 1'b1; xfer = 1'b1;
    @(negedge clk); we = 1'b0; xfer = 1'b0;
    rd_cnt(v); chk("R9 ctrl write does not block", v, 32'h0000550F);
    rd_adr(v); chk("R9 address steps with ctrl write", v, 32'h121);
  endtask

  task automatic t_irq();
    load(24'h000001, 32'h0);
    wr(4'd8, 8'h02);
    pulses(1);
    #1 chk("R10 done masked", {31'h0, irq}, 32'h0);
    wr(4'd8, 8'h01);
    #1 chk("R10 done enabled", {31'h0, irq}, 32'h1);
    wr(4'd7, 8'h01);
    #1 chk("R10 cleared flag drops irq", {31'h0, irq}, 32'h0);
    wr(4'd8, 8'h02);
    pulses(1);
    #1 chk("R10 wrap enabled", {31'h0, irq}, 32'h1);
    wr(4'd7, 8'h03);
  endtask

  task automatic t_unmapped();
    logic [31:0] v; logic [7:0] d;
    load(24'h0000AA, 32'h0000BBBB);
    for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 9; a < 16; a++) begin
      rd(4'(a), d); chk("R11 unmapped reads zero", {24'h0, d}, 32'h0);
    end
    rd_cnt(v); chk("R11 count unaffected", v, 32'hAA);
    rd_adr(v); chk("R11 address unaffected", v, 32'hBBBB);
    rd(4'd8, d); chk("R11 ctrl unaffected", {24'h0, d}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lanes();
    t_done_wrap();
    t_set_wins();
    t_clear_cmd();
    t_collide();
    t_irq();
    t_unmapped();
    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule